// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block merges a set of interrupt request lines into one interrupt line toward the processor, and gives the index of the source the processor should service next. A rising edge on a request line records that source as pending. A pending source that is unmasked, while the global enable is set, competes on fixed priority: the lowest index wins. The processor accepts the offered source with a one-cycle acknowledge pulse. That pulse moves the source from pending to in service. It reports the end of the handler with a one-cycle end-of-service pulse.

There are two service policies. In sequential mode, nothing is offered while any handler is in service. Requests that arrive meanwhile stay pending, and the next one is offered once the handler ends. In nested mode, a request is offered only if it outranks every source now in service. It then preempts the running handler. Ending a handler releases the highest-ranked in-service source, which returns service to the preempted level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `cpu_irq` is low, and no source is pending or in service.
- R2: A 0-to-1 transition on `irq_req[i]` sets source i pending one clock later. A request held high creates exactly one pending event.
- R3: A pending source is kept while `glob_en` is low or the source is masked. It is offered once it becomes eligible.
- R4: A source whose `mask[i]` bit is 1 is never offered on `cpu_irq`/`src_id`.
- R5: `src_id` equals the lowest index among the eligible pending sources whenever `cpu_irq` is high (index 0 has the highest priority).
- R6: When `nest_mode` is 0 (sequential), `cpu_irq` stays low while any source is in service.
- R7: `ack` while `cpu_irq` is high clears the pending bit of `src_id` and marks that source in service. `ack` while `cpu_irq` is low has no effect.
- R8: `eoi` clears the lowest-index in-service source. Any remaining eligible pending source is then offered again under the active mode.
- R9: When `nest_mode` is 1 (nested), an eligible pending source with an index lower than every in-service source raises `cpu_irq` even while a handler runs.
- R10: When `nest_mode` is 1, an eligible pending source whose index is not lower than the highest-ranked in-service source is not offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | NSRC | Request lines, one per source, edge-detected |
| mask | input | NSRC | Per-source mask, 1 blocks the source |
| glob_en | input | 1 | Global enable for offering interrupts |
| nest_mode | input | 1 | 0 sequential, 1 nested priority |
| ack | input | 1 | Processor accepts the offered source |
| eoi | input | 1 | Processor ends the current handler |
| cpu_irq | output | 1 | Interrupt line to the processor |
| src_id | output | IDW | Index of the offered source, valid while cpu_irq is high |

## Verification
Directed sequences run in both modes. They separate sequential masking from nested preemption, preemption by a higher source from the wait of a lower or equal one, and a return to the preempted level after end-of-service. Further cases cover requests held across the global enable and the mask, a level held high that must not re-arm, and an acknowledge with nothing offered. Seeded random traffic on all inputs then compares the line and the index each cycle against a bench model of the pending and in-service sets, which exposes priority and ordering slips that the directed cases miss.

// File: rtl/irq_prio_pkg.sv
// Shared definitions for the prioritized interrupt controller.
// Assumes sources are ranked by index, index 0 highest.
package irq_prio_pkg;
    typedef enum logic {
        SVC_SEQ  = 1'b0,
        SVC_NEST = 1'b1
    } svc_mode_e;
endpackage

// File: rtl/irq_pick.sv
// Fixed-priority picker: reports whether any bit is set and the lowest set index.
// Assumes IW is wide enough to hold W-1.
module irq_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the lowest rank upward so the lowest set index wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pend_bank.sv
// Per-source edge capture and pending latches.
// Assumes request lines are synchronous to clk; a rising edge outranks a same-cycle clear.
module irq_pend_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         hold_en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;

    for (genvar g = 0; g < N; g++) begin : g_src
        // Remember the previous level and latch a pending flag on a rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
                pend[g]  <= 1'b0;
            end else begin
                req_q[g] <= req[g];
                if (req[g] && !req_q[g]) pend[g] <= 1'b1;
                else if (clr[g])         pend[g] <= 1'b0;
            end
        end
    end

    // R3: a pending flag only falls through an explicit clear
    p_pend_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0) |=> (($past(pend) & ~pend) == '0));
    // R2: an edge always leaves the source pending
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && (req & ~req_q) != '0) |=> (($past(req & ~req_q) & ~pend) == '0));
endmodule

// File: rtl/irq_isr_stack.sv
// In-service set: ack adds a source, end-of-service removes the top-ranked one.
// Assumes set_vec is one-hot or zero.
module irq_isr_stack #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set_vec,
    input  logic          eoi,
    output logic          busy,
    output logic [IW-1:0] top_idx
);
    logic [N-1:0] isr;
    logic [N-1:0] done_vec;

    irq_pick #(.W(N), .IW(IW)) u_top (.vec(isr), .hit(busy), .idx(top_idx));

    // Select the bit that end-of-service releases.
    always_comb begin
        done_vec = '0;
        if (eoi && busy) done_vec[top_idx] = 1'b1;
    end

    // Update the in-service set.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~done_vec) | set_vec;
    end

    // R8: end-of-service without a new ack removes exactly one source
    p_eoi_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && busy && set_vec == '0) |=> ($countones(isr) == $countones($past(isr)) - 1));
    // R7: an accepted source is in service afterwards
    p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((isr & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Prioritized interrupt controller top: gates pending sources by enable and mask,
// picks the highest-ranked one, and applies the sequential or nested service policy.
// Assumes ack and eoi are single-cycle pulses from the processor.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] mask,
    input  logic            glob_en,
    input  logic            nest_mode,
    input  logic            ack,
    input  logic            eoi,
    output logic            cpu_irq,
    output logic [IDW-1:0]  src_id
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] take_vec;
    logic            e_hit;
    logic [IDW-1:0]  e_idx;
    logic            s_busy;
    logic [IDW-1:0]  s_top;
    logic            allow;
    svc_mode_e       mode;

    irq_pend_bank #(.N(NSRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req),
        .hold_en(glob_en), .clr(take_vec), .pend(pend)
    );

    irq_pick #(.W(NSRC), .IW(IDW)) u_pick (.vec(elig), .hit(e_hit), .idx(e_idx));

    irq_isr_stack #(.N(NSRC), .IW(IDW)) u_isr (
        .clk(clk), .rst_n(rst_n), .set_vec(take_vec), .eoi(eoi),
        .busy(s_busy), .top_idx(s_top)
    );

    // Eligible sources: pending, unmasked, globally enabled.
    always_comb elig = pend & ~mask & {NSRC{glob_en}};

    // Service policy: idle always admits; nested admits only a strictly higher rank.
    always_comb begin
        mode  = svc_mode_e'(nest_mode);
        allow = !s_busy || (mode == SVC_NEST && e_idx < s_top);
    end

    // Drive the processor line and the offered index.
    always_comb begin
        cpu_irq = e_hit && allow;
        src_id  = e_idx;
    end

    // Turn an accepted ack into a one-hot move from pending to in service.
    always_comb begin
        take_vec = '0;
        if (ack && cpu_irq) take_vec[e_idx] = 1'b1;
    end

    // R6: sequential mode offers nothing while a handler runs
    p_seq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_mode && s_busy) |-> !cpu_irq);
    // R4: a masked source is never offered
    p_mask_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> !mask[src_id]);
    // R10: nested mode offers only a rank above the running handler
    p_nest_rank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && s_busy) |-> (src_id < s_top));
    // R7: ack with nothing offered leaves the pending set intact
    p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !cpu_irq) |=> (($past(pend) & ~pend) == '0));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [N-1:0]  mask = '0;
    logic          glob_en = 1'b0;
    logic          nest_mode = 1'b0;
    logic          ack = 1'b0;
    logic          eoi = 1'b0;
    logic          cpu_irq;
    logic [IW-1:0] src_id;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model state
    logic [N-1:0] m_req_q = '0;
    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_isr = '0;

    always #10 clk = ~clk;

    irq_prio_ctrl #(.NSRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask(mask),
        .glob_en(glob_en), .nest_mode(nest_mode), .ack(ack), .eoi(eoi),
        .cpu_irq(cpu_irq), .src_id(src_id)
    );

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return N;
    endfunction

    function automatic logic exp_irq();
        int e = lowest(m_pend & ~mask & {N{glob_en}});
        int s = lowest(m_isr);
        if (e == N) return 1'b0;
        if (s == N) return 1'b1;
        return nest_mode && (e < s);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive inputs at the falling edge, check outputs, step the model.
    task automatic tick(input string tag, input logic [N-1:0] rq, input logic [N-1:0] mk,
                        input logic en, input logic nm, input logic ak, input logic eo);
        logic ei;
        int   e;
        int   s;
        logic [N-1:0] np;
        logic [N-1:0] ni;
        @(negedge clk);
        irq_req = rq; mask = mk; glob_en = en; nest_mode = nm; ack = ak; eoi = eo;
        #1;
        ei = exp_irq();
        e  = lowest(m_pend & ~mask & {N{glob_en}});
        chk(tag, int'(cpu_irq), int'(ei));
        if (ei) chk({tag, " id"}, int'(src_id), e);
        np = m_pend;
        ni = m_isr;
        if (ak && ei) begin np[e] = 1'b0; ni[e] = 1'b1; end
        s = lowest(m_isr);
        if (eo && s < N) ni[s] = 1'b0;
        if (ak && ei) ni[e] = 1'b1;
        np = np | (rq & ~m_req_q);
        @(posedge clk);
        m_pend = np; m_isr = ni; m_req_q = rq;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rq;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq", int'(cpu_irq), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // sequential mode: R2 edge, R5 pick, R7 ack, R6 hold-off, R8 next
        tick("R2", 8'h08, 8'h00, 1, 0, 0, 0);
        tick("R5", 8'h08, 8'h00, 1, 0, 0, 0);
        chk("R5 seen", int'(cpu_irq), 1);
        tick("R7", 8'h08, 8'h00, 1, 0, 1, 0);
        tick("R2 level", 8'h08, 8'h00, 1, 0, 0, 0);
        tick("R6", 8'h0A, 8'h00, 1, 0, 0, 0);
        tick("R6", 8'h0A, 8'h00, 1, 0, 0, 0);
        chk("R6 quiet", int'(cpu_irq), 0);
        tick("R8", 8'h0A, 8'h00, 1, 0, 0, 1);
        tick("R8", 8'h00, 8'h00, 1, 0, 0, 0);
        chk("R8 next id", int'(src_id), 1);
        tick("R8", 8'h00, 8'h00, 1, 0, 1, 0);
        tick("R8", 8'h00, 8'h00, 1, 0, 0, 1);

        // R7 idle ack, R3 disabled hold, R4 mask
        tick("R3", 8'h20, 8'h00, 0, 0, 0, 0);
        tick("R7 idle", 8'h20, 8'h00, 0, 0, 1, 0);
        tick("R4", 8'h20, 8'h20, 1, 0, 1, 0);
        chk("R4 hidden", int'(cpu_irq), 0);
        tick("R3", 8'h20, 8'h00, 1, 0, 0, 0);
        chk("R3 kept", int'(cpu_irq), 1);
        chk("R3 id", int'(src_id), 5);
        tick("R3", 8'h00, 8'h00, 1, 0, 1, 0);
        tick("R3", 8'h00, 8'h00, 1, 0, 0, 1);

        // nested mode: R9 preempt, R10 lower and equal wait, R8 return
        tick("R9", 8'h10, 8'h00, 1, 1, 0, 0);
        tick("R9", 8'h00, 8'h00, 1, 1, 1, 0);
        tick("R9", 8'h04, 8'h00, 1, 1, 0, 0);
        tick("R9", 8'h00, 8'h00, 1, 1, 0, 0);
        chk("R9 preempt", int'(cpu_irq), 1);
        tick("R9", 8'h00, 8'h00, 1, 1, 1, 0);
        tick("R10", 8'h44, 8'h00, 1, 1, 0, 0);
        tick("R10", 8'h44, 8'h00, 1, 1, 0, 0);
        chk("R10 wait", int'(cpu_irq), 0);
        tick("R8", 8'h00, 8'h00, 1, 1, 0, 1);
        chk("R8 lower still waits", int'(cpu_irq), 0);
        tick("R8", 8'h00, 8'h00, 1, 1, 0, 1);
        tick("R8", 8'h00, 8'h00, 1, 1, 0, 0);
        chk("R8 return id", int'(src_id), 2);
        for (int k = 0; k < 4; k++) tick("R8", 8'h00, 8'h00, 1, 1, k % 2 == 0, k % 2 == 1);

        // random traffic checked against the model
        rq = '0;
        for (int k = 0; k < 4000; k++) begin
            rq = rq ^ (($urandom % 3 == 0) ? N'($urandom) : '0);
            tick("R5", rq, (($urandom % 4) == 0) ? N'($urandom) : '0,
                 ($urandom % 8) != 0, k >= 2000,
                 ($urandom % 3) == 0, ($urandom % 5) == 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule